// File: doc/BRIEF.md
# Strobed Serial Configuration Port

This block is a three-wire serial write port that loads two configuration registers of 18 bits each. A host shifts bits in on a serial data line, clocked by a serial clock, while an active-low strobe is held low. When the strobe returns high, the most recent 19 bits are decoded: the first 18 of them are the payload and the final one picks the target register. A value of 0 picks the data register and a value of 1 picks the control register.

The control register can be locked by a hardware input. While that input is high, frames aimed at the control register are thrown away. The data register accepts writes whatever the lock input does. The bit that falls off the far end of the shift register is driven on a serial output. Several ports can therefore be chained behind one strobe and updated together. The serial pins are brought into the system clock domain through two-flop synchronizers. A single-cycle pulse marks each register update. An active-low power-good input clears every register and keeps it cleared.

Top module: `serial_cfg_port`

## Requirements
- R1: A frame holds 19 bits: 18 payload bits followed by a select bit. The select bit is the last bit shifted in, bit 0 of the frame.
- R2: The data line is sampled on rising edges of the serial clock. The payload is shifted most significant bit first.
- R3: Bits shift only while the strobe is low. Serial clock edges that arrive while the strobe is high leave the shift register unchanged.
- R4: On a rising strobe edge, the payload goes to the data register when the select bit is 0, or to the control register when it is 1. The other register keeps its value.
- R5: Any number of bits may be clocked during one strobe-low period. Only the final 19 bits decide the write.
- R6: While the lock input is high, a frame with select bit 1 is discarded. Writes to the data register succeed regardless of the lock input.
- R7: The serial output carries the bit that leaves the top of the shift register. It changes only after a falling edge of the serial clock, so the value shifted in 19 bits earlier appears before the next rising edge.
- R8: While power-good is low, both registers, the shift register and the serial output are zero. They stay zero after power-good returns until new data is written.
- R9: Each register write produces one pulse, one system clock long, on that register's pulse output. The pulse appears in the same cycle that the new value does. A discarded frame produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pg_n | input | 1 | Power-good; low clears and holds all state (asynchronous) |
| ser_in | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial clock; data sampled on its rising edge |
| strobe_n | input | 1 | Active-low strobe; rising edge commits a frame |
| ctrl_lock | input | 1 | High blocks writes to the control register |
| data_reg | output | 18 | Data register contents |
| ctrl_reg | output | 18 | Control register contents |
| data_wr_pulse | output | 1 | One-cycle pulse on a data register write |
| ctrl_wr_pulse | output | 1 | One-cycle pulse on a control register write |
| ser_out | output | 1 | Serial output for chaining |

## Verification
The assertions assume the serial clock and the strobe change slowly compared with the system clock, so that every edge survives the synchronizers as its own event. They also assume the lock input is stable across a strobe edge. The stimulus holds each serial clock phase for several system clocks. It leaves a margin of several cycles between the strobe moving and any serial clock edge, and it changes the lock input only while the strobe is high and idle.

// File: rtl/scp_pkg.sv
package scp_pkg;
    localparam int SCP_DATA_W = 18;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_CTRL = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;
endmodule

// File: rtl/scp_shifter.sv
module scp_shifter #(
    parameter int FRAME_W = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               out_en,
    input  logic               din,
    output logic [FRAME_W-1:0] frame,
    output logic               dout
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
        logic               so;
    } shf_t;

    shf_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        // new bits enter at the bottom; the oldest bit sits at the top
        if (shift_en) sh_d.sr = {sh_q.sr[FRAME_W-2:0], din};
        // the serial output follows the top bit on the serial clock's falling edge
        if (out_en)   sh_d.so = sh_q.sr[FRAME_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign frame = sh_q.sr;
    assign dout  = sh_q.so;
endmodule

// File: rtl/scp_regbank.sv
module scp_regbank
    import scp_pkg::*;
#(
    parameter int DATA_W = 18,
    localparam int FRAME_W = DATA_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               commit,
    input  logic [FRAME_W-1:0] frame,
    input  logic               lock,
    output logic [DATA_W-1:0]  data_reg,
    output logic [DATA_W-1:0]  ctrl_reg,
    output logic               data_pulse,
    output logic               ctrl_pulse
);
    typedef struct packed {
        logic [DATA_W-1:0] dat;
        logic [DATA_W-1:0] ctl;
        logic              dp;
        logic              cp;
    } bank_t;

    bank_t bk_d, bk_q;
    reg_sel_e sel;
    logic [DATA_W-1:0] payload;

    assign sel     = reg_sel_e'(frame[0]);
    assign payload = frame[FRAME_W-1:1];

    always_comb begin
        bk_d    = bk_q;
        bk_d.dp = 1'b0;
        bk_d.cp = 1'b0;
        if (commit) begin
            if (sel == SEL_DATA) begin
                bk_d.dat = payload;
                bk_d.dp  = 1'b1;
            end else if (!lock) begin
                bk_d.ctl = payload;
                bk_d.cp  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '0;
        else        bk_q <= bk_d;
    end

    assign data_reg   = bk_q.dat;
    assign ctrl_reg   = bk_q.ctl;
    assign data_pulse = bk_q.dp;
    assign ctrl_pulse = bk_q.cp;
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
    import scp_pkg::*;
#(
    parameter int DATA_W = SCP_DATA_W
) (
    input  logic              clk,
    input  logic              pg_n,
    input  logic              ser_in,
    input  logic              ser_clk,
    input  logic              strobe_n,
    input  logic              ctrl_lock,
    output logic [DATA_W-1:0] data_reg,
    output logic [DATA_W-1:0] ctrl_reg,
    output logic              data_wr_pulse,
    output logic              ctrl_wr_pulse,
    output logic              ser_out
);
    localparam int FRAME_W = DATA_W + 1;
    localparam int N_SYNC  = 3;
    localparam int IDX_DAT = 0;
    localparam int IDX_CLK = 1;
    localparam int IDX_STB = 2;

    logic [N_SYNC-1:0] raw_pins, sync_pins;
    assign raw_pins = {strobe_n, ser_clk, ser_in};

    scp_sync #(.W(N_SYNC)) u_sync (
        .clk      (clk),
        .rst_n    (pg_n),
        .async_in (raw_pins),
        .sync_out (sync_pins)
    );

    typedef struct packed {
        logic clk_prev;
        logic stb_prev;
    } edge_t;

    edge_t eg_d, eg_q;
    logic sclk_rise, sclk_fall, stb_rise, shift_en;

    always_comb begin
        eg_d.clk_prev = sync_pins[IDX_CLK];
        eg_d.stb_prev = sync_pins[IDX_STB];
    end

    // the strobe's previous sample resets high, its resting level
    always_ff @(posedge clk or negedge pg_n) begin
        if (!pg_n) eg_q <= '{clk_prev: 1'b0, stb_prev: 1'b1};
        else       eg_q <= eg_d;
    end

    assign sclk_rise = sync_pins[IDX_CLK] & ~eg_q.clk_prev;
    assign sclk_fall = ~sync_pins[IDX_CLK] & eg_q.clk_prev;
    assign stb_rise  = sync_pins[IDX_STB] & ~eg_q.stb_prev;
    assign shift_en  = sclk_rise & ~sync_pins[IDX_STB];

    logic [FRAME_W-1:0] frame;

    scp_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (pg_n),
        .shift_en (shift_en),
        .out_en   (sclk_fall),
        .din      (sync_pins[IDX_DAT]),
        .frame    (frame),
        .dout     (ser_out)
    );

    scp_regbank #(.DATA_W(DATA_W)) u_bank (
        .clk        (clk),
        .rst_n      (pg_n),
        .commit     (stb_rise),
        .frame      (frame),
        .lock       (ctrl_lock),
        .data_reg   (data_reg),
        .ctrl_reg   (ctrl_reg),
        .data_pulse (data_wr_pulse),
        .ctrl_pulse (ctrl_wr_pulse)
    );
endmodule

// File: rtl/scp_checker.sv
module scp_checker #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              pg_n,
    input logic              ctrl_lock,
    input logic [DATA_W-1:0] data_reg,
    input logic [DATA_W-1:0] ctrl_reg,
    input logic              data_wr_pulse,
    input logic              ctrl_wr_pulse,
    input logic              ser_out
);
    assert_data_change_has_pulse_R4: assert property (@(posedge clk) disable iff (!pg_n)
        (data_reg != $past(data_reg)) |-> data_wr_pulse);

    assert_ctrl_change_has_pulse_R4: assert property (@(posedge clk) disable iff (!pg_n)
        (ctrl_reg != $past(ctrl_reg)) |-> ctrl_wr_pulse);

    assert_locked_no_ctrl_write_R6: assert property (@(posedge clk) disable iff (!pg_n)
        ctrl_wr_pulse |-> !$past(ctrl_lock));

    assert_data_pulse_single_R9: assert property (@(posedge clk) disable iff (!pg_n)
        data_wr_pulse |=> !data_wr_pulse);

    assert_ctrl_pulse_single_R9: assert property (@(posedge clk) disable iff (!pg_n)
        ctrl_wr_pulse |=> !ctrl_wr_pulse);

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (!pg_n)
        !(data_wr_pulse && ctrl_wr_pulse));

    assert_cleared_in_reset_R8: assert property (@(posedge clk)
        !pg_n |-> (data_reg == '0 && ctrl_reg == '0 && !ser_out
                   && !data_wr_pulse && !ctrl_wr_pulse));
endmodule

bind serial_cfg_port scp_checker #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .pg_n          (pg_n),
    .ctrl_lock     (ctrl_lock),
    .data_reg      (data_reg),
    .ctrl_reg      (ctrl_reg),
    .data_wr_pulse (data_wr_pulse),
    .ctrl_wr_pulse (ctrl_wr_pulse),
    .ser_out       (ser_out)
);

// File: tb/serial_cfg_port_bench.sv
`timescale 1ns/1ps
module serial_cfg_port_bench;
    localparam int DW = 18;
    localparam int FW = DW + 1;
    localparam int HALF = 6;

    logic clk = 1'b0;
    logic pg_n = 1'b0;
    logic ser_in = 1'b0;
    logic ser_clk = 1'b0;
    logic strobe_n = 1'b1;
    logic ctrl_lock = 1'b0;
    logic [DW-1:0] data_reg, ctrl_reg;
    logic data_wr_pulse, ctrl_wr_pulse, ser_out;

    int n_checks = 0;
    int n_fail = 0;
    int n_dp = 0;
    int n_cp = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    serial_cfg_port #(.DATA_W(DW)) u_serial_cfg_port (
        .clk(clk), .pg_n(pg_n), .ser_in(ser_in), .ser_clk(ser_clk),
        .strobe_n(strobe_n), .ctrl_lock(ctrl_lock), .data_reg(data_reg),
        .ctrl_reg(ctrl_reg), .data_wr_pulse(data_wr_pulse),
        .ctrl_wr_pulse(ctrl_wr_pulse), .ser_out(ser_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (data_wr_pulse) n_dp <= n_dp + 1;
        if (ctrl_wr_pulse) n_cp <= n_cp + 1;
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            n_fail = n_fail + 1;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // shifts n bits of v, most significant first, without touching the strobe
    task automatic shift_bits(input logic [63:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_in = v[i];
            wait_clk(HALF);
            ser_clk = 1'b1;
            wait_clk(HALF);
            ser_clk = 1'b0;
        end
        wait_clk(HALF);
    endtask

    task automatic strobe_open;
        strobe_n = 1'b0;
        wait_clk(8);
    endtask

    task automatic strobe_close;
        wait_clk(4);
        strobe_n = 1'b1;
        wait_clk(8);
    endtask

    task automatic send(input logic [63:0] v, input int n);
        strobe_open();
        shift_bits(v, n);
        strobe_close();
    endtask

    function automatic logic [63:0] mk(input logic [DW-1:0] payload, input logic sel);
        return 64'({payload, sel});
    endfunction

    task automatic test_reset;
        check("R8 reset data_reg", 32'(data_reg), 32'h0);
        check("R8 reset ctrl_reg", 32'(ctrl_reg), 32'h0);
        check("R8 reset ser_out", 32'(ser_out), 32'h0);
    endtask

    task automatic test_data_write;
        int dp0 = n_dp, cp0 = n_cp;
        send(mk(18'h2A5A5, 1'b0), FW);
        check("R1 R2 R4 data write", 32'(data_reg), 32'h2A5A5);
        check("R4 ctrl untouched", 32'(ctrl_reg), 32'h0);
        check("R9 data pulse count", 32'(n_dp - dp0), 32'd1);
        check("R9 no ctrl pulse", 32'(n_cp - cp0), 32'd0);
    endtask

    task automatic test_ctrl_write;
        int cp0 = n_cp;
        send(mk(18'h1C3E7, 1'b1), FW);
        check("R4 ctrl write", 32'(ctrl_reg), 32'h1C3E7);
        check("R4 data untouched", 32'(data_reg), 32'h2A5A5);
        check("R9 ctrl pulse count", 32'(n_cp - cp0), 32'd1);
    endtask

    task automatic test_lock;
        int cp0, dp0;
        ctrl_lock = 1'b1;
        wait_clk(4);
        cp0 = n_cp;
        send(mk(18'h00FF0, 1'b1), FW);
        check("R6 locked ctrl kept", 32'(ctrl_reg), 32'h1C3E7);
        check("R9 no pulse on discard", 32'(n_cp - cp0), 32'd0);
        dp0 = n_dp;
        send(mk(18'h3F00F, 1'b0), FW);
        check("R6 data writable when locked", 32'(data_reg), 32'h3F00F);
        check("R9 data pulse when locked", 32'(n_dp - dp0), 32'd1);
        ctrl_lock = 1'b0;
        wait_clk(4);
    endtask

    task automatic test_ignore_strobe_high;
        int dp0;
        send(mk(18'h12345, 1'b0), FW);
        shift_bits(mk(18'h0ABCD, 1'b0), FW);
        dp0 = n_dp;
        strobe_open();
        strobe_close();
        check("R3 clocks with strobe high ignored", 32'(data_reg), 32'h12345);
        check("R3 rewrite pulse", 32'(n_dp - dp0), 32'd1);
    endtask

    task automatic test_long_frame;
        logic [63:0] v;
        v = (64'h2B << FW) | mk(18'h05A5A, 1'b1);
        send(v, FW + 6);
        check("R5 last 19 bits only", 32'(ctrl_reg), 32'h05A5A);
        check("R5 data untouched", 32'(data_reg), 32'h12345);
    endtask

    task automatic test_chain;
        logic [FW-1:0] x, y, got;
        x = {18'h2C71D, 1'b0};
        y = {18'h13B62, 1'b0};
        send(64'(x), FW);
        strobe_open();
        for (int i = FW - 1; i >= 0; i--) begin
            ser_in = y[i];
            wait_clk(HALF);
            got[i] = ser_out;
            ser_clk = 1'b1;
            wait_clk(HALF);
            ser_clk = 1'b0;
        end
        wait_clk(HALF);
        strobe_close();
        check("R7 serial output carries earlier frame", 32'(got), 32'(x));
        check("R7 chained write lands", 32'(data_reg), 32'h13B62);
    endtask

    task automatic test_power_fail;
        int dp0;
        send(mk(18'h3FFFF, 1'b1), FW);
        check("R4 ctrl all ones", 32'(ctrl_reg), 32'h3FFFF);
        wait_clk(2);
        pg_n = 1'b0;
        wait_clk(3);
        check("R8 data cleared", 32'(data_reg), 32'h0);
        check("R8 ctrl cleared", 32'(ctrl_reg), 32'h0);
        pg_n = 1'b1;
        wait_clk(10);
        check("R8 stays zero data", 32'(data_reg), 32'h0);
        check("R8 stays zero ctrl", 32'(ctrl_reg), 32'h0);
        dp0 = n_dp;
        strobe_open();
        strobe_close();
        check("R8 shift register cleared", 32'(data_reg), 32'h0);
        check("R8 zero frame selects data", 32'(n_dp - dp0), 32'd1);
        check("R8 ctrl still zero", 32'(ctrl_reg), 32'h0);
    endtask

    initial begin
        wait_clk(5);
        test_reset();
        pg_n = 1'b1;
        wait_clk(5);
        test_reset();
        test_data_write();
        test_ctrl_write();
        test_lock();
        test_ignore_strobe_high();
        test_long_frame();
        test_chain();
        test_power_fail();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule